// File: doc/BRIEF.md
# Set-Associative Tag Lookup with Age-Counter Replacement

This block holds the tag state of a set-associative cache and resolves one lookup per cycle. A request names a set, a tag and whether it is a write. The block answers one cycle later. The answer says whether the request hit and in which way, which way should be replaced, whether that way is dirty and what tag it holds. In write-back mode it can also raise a write-back request for a dirty victim. In write-through mode it raises a memory write request for every write. The line address used in these requests is the tag placed directly above the set index bits.

Each way of each set keeps a valid bit, a dirty bit, a tag and a small age counter. A lookup clears the age of the way it hits. It ages every other valid way by one, and the counter stops at its maximum value. Line data, miss tracking and the memory side are outside this block. A separate fill port installs a tag into a chosen way once the line has arrived.

Top module: `set_tag_lookup`

## Requirements
- R1: After reset every way of every set is invalid and the eviction count is zero. `rsp_valid`, `wb_valid` and `wt_valid` are low, and the first lookup misses.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. All lookup outputs belong to that request.
- R3: A lookup hits when a valid way of the set holds the request tag. `rsp_hit_way` gives the lowest-numbered such way, and the age of every matching way returns to zero.
- R4: During a lookup, each valid way whose tag differs has its age raised by one. The age stays at 2^AGE_W-1 once it reaches it. Invalid ways keep their age.
- R5: If the set has an invalid way, `rsp_victim_way` is the highest-numbered invalid way.
- R6: If every way is valid, `rsp_victim_way` is the way with the largest age as it stood before the lookup. On a tie the lowest-numbered way wins, and way 0 is chosen when all ages are zero.
- R7: With POLICY = WR_BACK (1), a write hit marks every matching way dirty. `rsp_victim_dirty` is high when the victim way is valid and dirty.
- R8: With POLICY = WR_BACK, a miss in a set with no invalid way and a dirty victim raises `wb_valid` for one cycle. `wb_addr` is {victim tag, set}, and `evict_count` rises by one. A clean victim raises neither.
- R9: With POLICY = WR_THROUGH (0), every write, hit or miss, raises `wt_valid` with `wt_addr` = {request tag, set}, and no way is ever dirty. With WR_BACK, `wt_valid` never rises.
- R10: A fill makes the addressed way valid with the fill tag, clean and with age zero. When a lookup arrives in the same cycle, the lookup sees the state before the fill, and the fill wins for its way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_set | input | SET_W | Set index of the lookup |
| req_tag | input | TAG_W | Tag of the lookup |
| req_write | input | 1 | Lookup is a write |
| fill_valid | input | 1 | Install a tag into a way |
| fill_set | input | SET_W | Set index of the fill |
| fill_way | input | WAY_W | Way written by the fill |
| fill_tag | input | TAG_W | Tag installed by the fill |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_hit_way | output | WAY_W | Lowest matching way |
| rsp_victim_way | output | WAY_W | Way chosen for replacement |
| rsp_victim_dirty | output | 1 | Victim way is valid and dirty |
| rsp_victim_tag | output | TAG_W | Tag stored in the victim way |
| wb_valid | output | 1 | Write-back of the dirty victim requested |
| wb_addr | output | TAG_W+SET_W | Line address of the victim |
| wt_valid | output | 1 | Write-through memory write requested |
| wt_addr | output | TAG_W+SET_W | Line address of the written line |
| evict_count | output | CNT_W | Number of write-backs raised |

## Verification
On every cycle, the assertions check four things: the one-cycle response timing, that a write-back only follows a dirty miss and moves the eviction count by exactly one, that a lookup clears the age of a hit way and keeps a saturated age saturated, and that a fill leaves its way valid and young. The victim order across several ways also needs checking: highest free way first, otherwise oldest with ties to the lowest index. So does the way dirtiness gathered by earlier writes later turns into a write-back address. Only the bench can show these, by replaying long mixed sequences of lookups and fills against its own model of every set. Both write policies are run side by side on the same stimulus.

// File: rtl/stl_pkg.sv
package stl_pkg;

    typedef enum logic {
        WR_THROUGH = 1'b0,
        WR_BACK    = 1'b1
    } wr_policy_e;

    typedef struct packed {
        logic hit;
        logic free;
        logic vdirty;
        logic wb;
        logic wt;
    } lk_flags_t;

endpackage

// File: rtl/stl_way_entry.sv
module stl_way_entry #(
    parameter int NUM_SETS = 4,
    parameter int TAG_W    = 8,
    parameter int AGE_W    = 3,
    parameter bit WB_EN    = 1'b1,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_en,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             lk_write,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [TAG_W-1:0] fill_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    output logic [AGE_W-1:0] rd_age,
    output logic             rd_match
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic [NUM_SETS-1:0] valid_q;
    logic [NUM_SETS-1:0] dirty_q;
    logic [TAG_W-1:0]    tag_q [NUM_SETS];
    logic [AGE_W-1:0]    age_q [NUM_SETS];

    assign rd_valid = valid_q[lk_set];
    assign rd_dirty = dirty_q[lk_set];
    assign rd_tag   = tag_q[lk_set];
    assign rd_age   = age_q[lk_set];
    assign rd_match = valid_q[lk_set] && (tag_q[lk_set] == lk_tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int s = 0; s < NUM_SETS; s++) begin
                tag_q[s] <= '0;
                age_q[s] <= '0;
            end
        end else begin
            if (lk_en && valid_q[lk_set]) begin
                if (tag_q[lk_set] == lk_tag) begin
                    age_q[lk_set] <= '0;
                    if (lk_write && WB_EN)
                        dirty_q[lk_set] <= 1'b1;
                end else if (age_q[lk_set] != AGE_MAX) begin
                    age_q[lk_set] <= age_q[lk_set] + 1'b1;
                end
            end
            if (fill_en) begin
                valid_q[fill_set] <= 1'b1;
                dirty_q[fill_set] <= 1'b0;
                tag_q[fill_set]   <= fill_tag;
                age_q[fill_set]   <= '0;
            end
        end
    end

    // R3
    hit_age_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_en && !fill_en && rd_match) |=> (age_q[$past(lk_set)] == '0));

    // R4
    age_saturate_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_en && !fill_en && rd_valid && !rd_match && rd_age == AGE_MAX)
        |=> (age_q[$past(lk_set)] == AGE_MAX));

    // R10
    fill_install_chk: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (valid_q[$past(fill_set)] && !dirty_q[$past(fill_set)]
                     && age_q[$past(fill_set)] == '0));

endmodule

// File: rtl/stl_victim_pick.sv
module stl_victim_pick #(
    parameter int NUM_WAYS = 4,
    parameter int AGE_W    = 3,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0] way_valid,
    input  logic [AGE_W-1:0]    way_age [NUM_WAYS],
    output logic                any_free,
    output logic [WAY_W-1:0]    victim_way
);
    logic [WAY_W-1:0] oldest_way;
    logic [WAY_W-1:0] free_way;
    logic [AGE_W-1:0] oldest_age;

    always_comb begin
        oldest_way = '0;
        oldest_age = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (way_age[i] > oldest_age) begin
                oldest_age = way_age[i];
                oldest_way = WAY_W'(i);
            end
        end
    end

    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (!way_valid[i]) begin
                any_free = 1'b1;
                free_way = WAY_W'(i);
            end
        end
    end

    assign victim_way = any_free ? free_way : oldest_way;

endmodule

// File: rtl/set_tag_lookup.sv
module set_tag_lookup
    import stl_pkg::*;
#(
    parameter int         NUM_SETS = 4,
    parameter int         NUM_WAYS = 4,
    parameter int         TAG_W    = 8,
    parameter int         AGE_W    = 3,
    parameter int         CNT_W    = 16,
    parameter wr_policy_e POLICY   = WR_BACK,
    localparam int        SET_W    = $clog2(NUM_SETS),
    localparam int        WAY_W    = $clog2(NUM_WAYS),
    localparam int        LINE_W   = TAG_W + SET_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [SET_W-1:0]  req_set,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              req_write,
    input  logic              fill_valid,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_hit_way,
    output logic [WAY_W-1:0]  rsp_victim_way,
    output logic              rsp_victim_dirty,
    output logic [TAG_W-1:0]  rsp_victim_tag,
    output logic              wb_valid,
    output logic [LINE_W-1:0] wb_addr,
    output logic              wt_valid,
    output logic [LINE_W-1:0] wt_addr,
    output logic [CNT_W-1:0]  evict_count
);
    localparam bit WB_EN = (POLICY == WR_BACK);

    logic [NUM_WAYS-1:0] way_valid;
    logic [NUM_WAYS-1:0] way_dirty;
    logic [NUM_WAYS-1:0] way_match;
    logic [TAG_W-1:0]    way_tag [NUM_WAYS];
    logic [AGE_W-1:0]    way_age [NUM_WAYS];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        stl_way_entry #(
            .NUM_SETS (NUM_SETS),
            .TAG_W    (TAG_W),
            .AGE_W    (AGE_W),
            .WB_EN    (WB_EN)
        ) u_entry (
            .clk      (clk),
            .rst      (rst),
            .lk_en    (req_valid),
            .lk_set   (req_set),
            .lk_tag   (req_tag),
            .lk_write (req_write),
            .fill_en  (fill_valid && (fill_way == WAY_W'(w))),
            .fill_set (fill_set),
            .fill_tag (fill_tag),
            .rd_valid (way_valid[w]),
            .rd_dirty (way_dirty[w]),
            .rd_tag   (way_tag[w]),
            .rd_age   (way_age[w]),
            .rd_match (way_match[w])
        );
    end

    logic             any_free;
    logic [WAY_W-1:0] victim_way;

    stl_victim_pick #(
        .NUM_WAYS (NUM_WAYS),
        .AGE_W    (AGE_W)
    ) u_victim (
        .way_valid  (way_valid),
        .way_age    (way_age),
        .any_free   (any_free),
        .victim_way (victim_way)
    );

    logic [WAY_W-1:0] hit_way;
    always_comb begin
        hit_way = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (way_match[i])
                hit_way = WAY_W'(i);
        end
    end

    lk_flags_t fl;
    always_comb begin
        fl.hit    = |way_match;
        fl.free   = any_free;
        fl.vdirty = way_valid[victim_way] && way_dirty[victim_way];
        fl.wb     = WB_EN && !fl.hit && !fl.free && fl.vdirty;
        fl.wt     = !WB_EN && req_write;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid        <= 1'b0;
            rsp_hit          <= 1'b0;
            rsp_hit_way      <= '0;
            rsp_victim_way   <= '0;
            rsp_victim_dirty <= 1'b0;
            rsp_victim_tag   <= '0;
            wb_valid         <= 1'b0;
            wb_addr          <= '0;
            wt_valid         <= 1'b0;
            wt_addr          <= '0;
            evict_count      <= '0;
        end else begin
            rsp_valid <= req_valid;
            wb_valid  <= req_valid && fl.wb;
            wt_valid  <= req_valid && fl.wt;
            if (req_valid) begin
                rsp_hit          <= fl.hit;
                rsp_hit_way      <= hit_way;
                rsp_victim_way   <= victim_way;
                rsp_victim_dirty <= fl.vdirty;
                rsp_victim_tag   <= way_tag[victim_way];
                wb_addr          <= {way_tag[victim_way], req_set};
                wt_addr          <= {req_tag, req_set};
                if (fl.wb)
                    evict_count <= evict_count + 1'b1;
            end
        end
    end

    // R2
    rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R5
    free_victim_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && any_free) |-> !way_valid[victim_way]);

    // R8
    wb_dirty_miss_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (rsp_valid && !rsp_hit && rsp_victim_dirty));

    // R8
    evict_step_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (evict_count == $past(evict_count) + 1'b1));

    // R8
    evict_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wb_valid |-> $stable(evict_count));

    // R9
    wt_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        wt_valid |-> (rsp_valid && !WB_EN));

endmodule

// File: tb/tb_set_tag_lookup.sv
module tb_set_tag_lookup;
    import stl_pkg::*;

    localparam int SETS  = 4;
    localparam int WAYS  = 4;
    localparam int TAG_W = 8;
    localparam int AGE_W = 3;
    localparam int SET_W = 2;
    localparam int WAY_W = 2;
    localparam int AMAX  = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic             req_valid = 1'b0;
    logic [SET_W-1:0] req_set   = '0;
    logic [TAG_W-1:0] req_tag   = '0;
    logic             req_write = 1'b0;
    logic             fill_valid = 1'b0;
    logic [SET_W-1:0] fill_set  = '0;
    logic [WAY_W-1:0] fill_way  = '0;
    logic [TAG_W-1:0] fill_tag  = '0;

    logic             rv [2];
    logic             rh [2];
    logic [WAY_W-1:0] rhw [2];
    logic [WAY_W-1:0] rvw [2];
    logic             rvd [2];
    logic [TAG_W-1:0] rvt [2];
    logic             wbv [2];
    logic [9:0]       wba [2];
    logic             wtv [2];
    logic [9:0]       wta [2];
    logic [15:0]      ecnt [2];

    set_tag_lookup #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W),
                     .CNT_W(16), .POLICY(WR_BACK)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_set(req_set),
        .req_tag(req_tag), .req_write(req_write), .fill_valid(fill_valid),
        .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag),
        .rsp_valid(rv[0]), .rsp_hit(rh[0]), .rsp_hit_way(rhw[0]),
        .rsp_victim_way(rvw[0]), .rsp_victim_dirty(rvd[0]), .rsp_victim_tag(rvt[0]),
        .wb_valid(wbv[0]), .wb_addr(wba[0]), .wt_valid(wtv[0]), .wt_addr(wta[0]),
        .evict_count(ecnt[0]));

    set_tag_lookup #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W),
                     .CNT_W(16), .POLICY(WR_THROUGH)) dut_wt (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_set(req_set),
        .req_tag(req_tag), .req_write(req_write), .fill_valid(fill_valid),
        .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag),
        .rsp_valid(rv[1]), .rsp_hit(rh[1]), .rsp_hit_way(rhw[1]),
        .rsp_victim_way(rvw[1]), .rsp_victim_dirty(rvd[1]), .rsp_victim_tag(rvt[1]),
        .wb_valid(wbv[1]), .wb_addr(wba[1]), .wt_valid(wtv[1]), .wt_addr(wta[1]),
        .evict_count(ecnt[1]));

    // Bench model: index 0 is write-back, 1 is write-through
    bit mv [2][SETS][WAYS];
    bit md [2][SETS][WAYS];
    int mt [2][SETS][WAYS];
    int ma [2][SETS][WAYS];
    int mev [2];

    int checks = 0;
    int errors = 0;

    task automatic check(string req, string focus, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d", req, focus, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < 2; p++) begin
            mev[p] = 0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    mv[p][s][w] = 0; md[p][s][w] = 0; mt[p][s][w] = 0; ma[p][s][w] = 0;
                end
        end
    endtask

    // One cycle of stimulus, then checks of the registered result
    task automatic step(bit rq, int s, int t, bit wr, bit fl, int fs, int fw, int ft,
                        string focus);
        bit e_hit [2]; int e_hw [2]; int e_vw [2]; bit e_vd [2]; int e_vt [2];
        bit e_free [2]; bit e_wb [2]; bit e_wt [2]; int e_wba [2];
        @(negedge clk);
        req_valid = rq; req_set = SET_W'(s); req_tag = TAG_W'(t); req_write = wr;
        fill_valid = fl; fill_set = SET_W'(fs); fill_way = WAY_W'(fw); fill_tag = TAG_W'(ft);
        for (int p = 0; p < 2; p++) begin
            int cand; int maxa;
            e_hit[p] = 0; e_hw[p] = 0; e_free[p] = 0; e_vw[p] = 0;
            if (rq) begin
                for (int w = 0; w < WAYS; w++)
                    if (!e_hit[p] && mv[p][s][w] && mt[p][s][w] == t) begin
                        e_hit[p] = 1; e_hw[p] = w;
                    end
                cand = 0; maxa = 0;
                for (int w = 0; w < WAYS; w++)
                    if (ma[p][s][w] > maxa) begin maxa = ma[p][s][w]; cand = w; end
                for (int w = 0; w < WAYS; w++)
                    if (!mv[p][s][w]) begin e_free[p] = 1; e_vw[p] = w; end
                if (!e_free[p]) e_vw[p] = cand;
                e_vd[p]  = mv[p][s][e_vw[p]] && md[p][s][e_vw[p]];
                e_vt[p]  = mt[p][s][e_vw[p]];
                e_wb[p]  = (p == 0) && !e_hit[p] && !e_free[p] && e_vd[p];
                e_wt[p]  = (p == 1) && wr;
                e_wba[p] = e_vt[p] * SETS + s;
                if (e_wb[p]) mev[p]++;
                for (int w = 0; w < WAYS; w++)
                    if (mv[p][s][w]) begin
                        if (mt[p][s][w] == t) begin
                            ma[p][s][w] = 0;
                            if (wr && p == 0) md[p][s][w] = 1;
                        end else if (ma[p][s][w] < AMAX) begin
                            ma[p][s][w]++;
                        end
                    end
            end else begin
                e_wb[p] = 0; e_wt[p] = 0;
            end
            if (fl) begin
                mv[p][fs][fw] = 1; md[p][fs][fw] = 0; mt[p][fs][fw] = ft; ma[p][fs][fw] = 0;
            end
        end
        @(posedge clk);
        #1;
        for (int p = 0; p < 2; p++) begin
            check("R2", focus, "rsp_valid", int'(rv[p]), int'(rq));
            check("R8", focus, "evict_count", int'(ecnt[p]), mev[p]);
            check("R8", focus, "wb_valid", int'(wbv[p]), int'(e_wb[p]));
            check("R9", focus, "wt_valid", int'(wtv[p]), int'(e_wt[p]));
            if (rq) begin
                check("R3", focus, "rsp_hit", int'(rh[p]), int'(e_hit[p]));
                if (e_hit[p]) check("R3", focus, "rsp_hit_way", int'(rhw[p]), e_hw[p]);
                check(e_free[p] ? "R5" : "R6", focus, "rsp_victim_way", int'(rvw[p]), e_vw[p]);
                check("R7", focus, "rsp_victim_dirty", int'(rvd[p]), int'(e_vd[p]));
                if (!e_free[p]) check("R6", focus, "rsp_victim_tag", int'(rvt[p]), e_vt[p]);
                if (e_wb[p]) check("R8", focus, "wb_addr", int'(wba[p]), e_wba[p]);
                if (e_wt[p]) check("R9", focus, "wt_addr", int'(wta[p]), t * SETS + s);
            end
        end
    endtask

    task automatic lookup(int s, int t, bit wr, string focus);
        step(1'b1, s, t, wr, 1'b0, 0, 0, 0, focus);
    endtask

    task automatic fill(int s, int w, int t);
        step(1'b0, 0, 0, 1'b0, 1'b1, s, w, t, "R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 0 expected 1 (run completed)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240813));
        model_reset();
        rst = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        for (int p = 0; p < 2; p++) begin
            check("R1", "R1", "rsp_valid", int'(rv[p]), 0);
            check("R1", "R1", "wb_valid", int'(wbv[p]), 0);
            check("R1", "R1", "wt_valid", int'(wtv[p]), 0);
            check("R1", "R1", "evict_count", int'(ecnt[p]), 0);
        end
        @(negedge clk);
        rst = 1'b0;

        // R1: first lookup misses, highest free way chosen (R5)
        lookup(0, 5, 1'b0, "R1");
        // R10: fill then hit
        fill(0, 3, 5);
        lookup(0, 5, 1'b0, "R10");
        fill(0, 0, 1);
        fill(0, 1, 2);
        lookup(0, 9, 1'b0, "R5");
        fill(0, 2, 3);
        // R7 / R9: write hit on way 1
        lookup(0, 2, 1'b1, "R7");
        // R4: keep hitting way 3 so the others saturate
        for (int i = 0; i < 10; i++) lookup(0, 5, 1'b0, "R4");
        lookup(0, 1, 1'b0, "R4");
        // R8: full set miss, way 1 is oldest and dirty in write-back
        lookup(0, 9, 1'b0, "R8");
        lookup(0, 9, 1'b1, "R8");
        // R9: write miss in another set
        lookup(2, 11, 1'b1, "R9");
        // R6: all-zero ages pick way 0
        fill(3, 0, 4); fill(3, 1, 5); fill(3, 2, 6); fill(3, 3, 7);
        lookup(3, 6, 1'b0, "R6");
        // R10: fill and lookup together on the same way
        step(1'b1, 0, 3, 1'b0, 1'b1, 0, 2, 12, "R10");
        lookup(0, 12, 1'b0, "R10");
        lookup(0, 3, 1'b0, "R10");

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            int k;
            k = int'($urandom % 10);
            if (k < 6)
                lookup(int'($urandom % SETS), int'($urandom % 6), 1'($urandom % 2), "R3");
            else if (k < 8)
                fill(int'($urandom % SETS), int'($urandom % WAYS), int'($urandom % 6));
            else if (k < 9)
                step(1'b1, int'($urandom % SETS), int'($urandom % 6), 1'($urandom % 2),
                     1'b1, int'($urandom % SETS), int'($urandom % WAYS), int'($urandom % 6),
                     "R10");
            else
                step(1'b0, 0, 0, 1'b0, 1'b0, 0, 0, 0, "R2");
        end
        step(1'b0, 0, 0, 1'b0, 1'b0, 0, 0, 0, "R2");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule